// File: doc/BRIEF.md
# Fractional UART Baud Tick Generator

This block turns a single module clock into the two timing enables a UART needs: a sample enable at sixteen times the bit rate for the receiver, and a bit enable for the transmitter. Both are one-cycle pulses on the module clock, so downstream logic stays in a single clock domain and simply qualifies its registers with them.

The spacing of sample enables is set by a 13-bit integer divisor and refined by a 5-bit fine-adjust value. A 5-bit phase accumulator gains the fine-adjust value at every sample enable. Whenever that sum overflows, the following period is one clock longer. Over 32 periods the average spacing is therefore the divisor plus fine-adjust/32 clocks. A new setting is picked up only when a period ends. A zero divisor halts the block and clears all of its phase state.

Top module: `baud_tick_gen`

## Requirements
- R1: While `rstN` is low, and in the cycle after it is released with `divisor` at zero, `sampleTick` and `bitTick` are both 0.
- R2: When `divisor` becomes a nonzero value D while the block is halted, the first `sampleTick` is high in the D-th cycle after the first rising edge that sees the nonzero value.
- R3: With `fineAdj` at 0 and a steady divisor D, consecutive `sampleTick` pulses are exactly D cycles apart.
- R4: A 5-bit accumulator starts at 0 and gains `fineAdj` at each `sampleTick`. When that addition carries past 31, the next period lasts D+1 cycles; otherwise it lasts D cycles. The first period after a start has no stretch.
- R5: `bitTick` is high only together with `sampleTick`, and only on the 16th, 32nd, 48th, ... sample tick counted from the last start.
- R6: A `divisor` of 0 on a rising edge halts the block from the next cycle on. No tick is produced, and the accumulator and the bit phase return to zero.
- R7: A change of a nonzero `divisor` or of `fineAdj` in the middle of a period does not alter that period. The new divisor governs the period that starts at the next tick.
- R8: With a divisor of 1 and `fineAdj` 0, `sampleTick` is high in every cycle.
- R9: The largest divisor, 8191, gives periods of 8191 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rstN | input | 1 | Asynchronous active-low reset |
| divisor | input | 13 | Integer clocks per sample period; 0 halts the block |
| fineAdj | input | 5 | Fractional extension in 1/32 clock steps |
| sampleTick | output | 1 | One-cycle 16x oversampling enable |
| bitTick | output | 1 | One-cycle bit-rate enable, coincident with every 16th sample tick |

## Verification
The bench tries every fine-adjust value with each divisor from 1 to 8. It checks every gap against an arithmetic model of the accumulator. A fine-adjust of 0 separates plain integer division from stretching. Values such as 1, 16 and 31 show whether the carry lands on the correct period rather than merely at the correct average rate. A divisor of 1 exposes off-by-one errors in the counter compare, because a stretched period there doubles the spacing. Separate runs change the divisor in the middle of a period, return it to zero in the middle of a period, and use the largest divisor. These runs tell boundary-aligned updates apart from immediate ones, and show whether a stop really clears the bit phase.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;
  typedef struct packed {
    logic clear;  // divisor zero: halt and reset all phase state
    logic load;   // capture settings and restart the period counter
    logic wrap;   // period ended: advance the fractional accumulator
  } strobe_t;
endpackage

// File: rtl/baud_tick_dp.sv
module baud_tick_dp
  import baud_tick_pkg::*;
#(
  parameter int DIV_W  = 13,
  parameter int FRAC_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  divisor,
  input  logic [FRAC_W-1:0] fineAdj,
  input  strobe_t           strb,
  output logic              running,
  output logic              periodDone
);
  localparam int CNT_W = DIV_W + 1;

  logic [DIV_W-1:0]  activeDiv;
  logic [FRAC_W-1:0] activeFine;
  logic [CNT_W-1:0]  cnt;
  logic [FRAC_W-1:0] acc;
  logic              stretch;
  logic [CNT_W-1:0]  periodLen;
  logic [FRAC_W:0]   accSum;

  assign running    = (activeDiv != '0);
  assign periodLen  = {1'b0, activeDiv} + CNT_W'(stretch);
  assign periodDone = running && (cnt == periodLen);
  assign accSum     = {1'b0, acc} + {1'b0, activeFine};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeDiv  <= '0;
      activeFine <= '0;
      cnt        <= CNT_W'(1);
      acc        <= '0;
      stretch    <= 1'b0;
    end else if (strb.clear) begin
      activeDiv  <= '0;
      activeFine <= '0;
      cnt        <= CNT_W'(1);
      acc        <= '0;
      stretch    <= 1'b0;
    end else if (strb.load) begin
      activeDiv  <= divisor;
      activeFine <= fineAdj;
      cnt        <= CNT_W'(1);
      if (strb.wrap) begin
        acc     <= accSum[FRAC_W-1:0];
        stretch <= accSum[FRAC_W];
      end
    end else if (running) begin
      cnt <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/baud_tick_ctrl.sv
module baud_tick_ctrl
  import baud_tick_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    divIsZero,
  input  logic    running,
  input  logic    periodDone,
  output strobe_t strb,
  output logic    sampleTick,
  output logic    bitTick
);
  localparam int PH_W = (OSR > 1) ? $clog2(OSR) : 1;
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(OSR - 1);

  logic [PH_W-1:0] phase;

  always_comb begin
    strb.clear = divIsZero;
    strb.wrap  = periodDone && !divIsZero;
    strb.load  = !divIsZero && (periodDone || !running);
  end

  assign sampleTick = periodDone;
  assign bitTick    = periodDone && (phase == LAST_PH);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               phase <= '0;
    else if (strb.clear)     phase <= '0;
    else if (periodDone)     phase <= (phase == LAST_PH) ? '0 : phase + PH_W'(1);
  end
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_tick_pkg::*;
#(
  parameter int DIV_W  = 13,
  parameter int FRAC_W = 5,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  divisor,
  input  logic [FRAC_W-1:0] fineAdj,
  output logic              sampleTick,
  output logic              bitTick
);
  strobe_t strb;
  logic    running;
  logic    periodDone;

  baud_tick_dp #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_dp (
    .clk(clk), .rstN(rstN), .divisor(divisor), .fineAdj(fineAdj),
    .strb(strb), .running(running), .periodDone(periodDone)
  );

  baud_tick_ctrl #(.OSR(OSR)) u_ctrl (
    .clk(clk), .rstN(rstN), .divIsZero(divisor == '0),
    .running(running), .periodDone(periodDone), .strb(strb),
    .sampleTick(sampleTick), .bitTick(bitTick)
  );
endmodule

// File: rtl/baud_tick_chk.sv
module baud_tick_chk #(
  parameter int DIV_W = 13,
  parameter int OSR   = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [DIV_W-1:0] divisor,
  input logic             sampleTick,
  input logic             bitTick
);
  logic [DIV_W+1:0] gapCnt;
  logic [DIV_W-1:0] heldDiv;
  logic             seenTick;
  int unsigned      tickNum;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt <= '0; heldDiv <= '0; seenTick <= 1'b0; tickNum <= 0;
    end else begin
      gapCnt <= sampleTick ? '0 : gapCnt + 1'b1;
      if (divisor == '0) begin
        seenTick <= 1'b0;
        tickNum  <= 0;
      end else if (sampleTick) begin
        seenTick <= 1'b1;
        heldDiv  <= divisor;
        tickNum  <= (tickNum == OSR - 1) ? 0 : tickNum + 1;
      end
    end
  end

  always @(posedge clk) begin
    if (!rstN) p_reset_quiet_r1: assert (!sampleTick && !bitTick);
  end

  p_zero_stops_r6: assert property (@(posedge clk) disable iff (!rstN)
    (divisor == '0) |=> !sampleTick);

  p_bit_with_sample_r5: assert property (@(posedge clk) disable iff (!rstN)
    bitTick |-> sampleTick);

  p_bit_phase_r5: assert property (@(posedge clk) disable iff (!rstN)
    (sampleTick && divisor != '0) |-> (bitTick == (tickNum == OSR - 1)));

  p_gap_r4: assert property (@(posedge clk) disable iff (!rstN)
    (sampleTick && seenTick && divisor != '0) |->
      ((gapCnt + 1'b1) == {2'b00, heldDiv} || (gapCnt + 1'b1) == {2'b00, heldDiv} + 1'b1));
endmodule

bind baud_tick_gen baud_tick_chk #(.DIV_W(DIV_W), .OSR(OSR)) u_chk (
  .clk(clk), .rstN(rstN), .divisor(divisor),
  .sampleTick(sampleTick), .bitTick(bitTick)
);

// File: tb/baud_tick_gen_tb.sv
module baud_tick_gen_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [12:0] divisor = '0;
  logic [4:0]  fineAdj = '0;
  logic        sampleTick, bitTick;
  int          nChecks = 0;
  int          nFails = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  baud_tick_gen u_dut (
    .clk(clk), .rstN(rstN), .divisor(divisor), .fineAdj(fineAdj),
    .sampleTick(sampleTick), .bitTick(bitTick)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Count negedges until sampleTick is seen; returns cycles (or limit+1 on timeout).
  task automatic waitTick(input int limit, output int cycles, output bit bitSeen);
    cycles = 0; bitSeen = 0;
    for (int k = 0; k <= limit; k++) begin
      @(negedge clk);
      cycles++;
      if (sampleTick) begin bitSeen = bitTick; return; end
    end
  endtask

  task automatic haltTwo();
    divisor = '0;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic runCfg(input int d, input int f, input int nTicks, input string req);
    int acc, stretch, gap, sum;
    bit bs;
    haltTwo();
    check("R6", int'(sampleTick), 0);
    divisor = 13'(d); fineAdj = 5'(f);
    acc = 0; stretch = 0;
    for (int t = 0; t < nTicks; t++) begin
      waitTick(d + 2, gap, bs);
      check(t == 0 ? "R2" : req, gap, d + stretch);
      check("R5", int'(bs), (t % 16 == 15) ? 1 : 0);
      sum = acc + f;
      stretch = (sum >= 32) ? 1 : 0;
      acc = sum % 32;
    end
  endtask

  initial begin
    int gap;
    bit bs;
    repeat (3) @(negedge clk);
    check("R1", int'(sampleTick), 0);
    check("R1", int'(bitTick), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", int'(sampleTick), 0);

    // R3 / R4 sweep: all fine-adjust values across small divisors
    for (int d = 1; d <= 8; d++)
      for (int f = 0; f < 32; f++)
        runCfg(d, f, 32, f == 0 ? "R3" : "R4");

    // R8: divisor 1 gives a tick every cycle
    haltTwo();
    divisor = 13'd1; fineAdj = 5'd0;
    @(negedge clk);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      check("R8", int'(sampleTick), 1);
    end

    // R7: mid-period change waits for the boundary
    runCfg(5, 0, 1, "R3");
    @(negedge clk); @(negedge clk);
    divisor = 13'd9; fineAdj = 5'd31;
    waitTick(8, gap, bs);
    check("R7", gap, 3);
    waitTick(12, gap, bs);
    check("R7", gap, 9);
    waitTick(12, gap, bs);
    check("R7", gap, 9);
    waitTick(12, gap, bs);
    check("R7", gap, 10);

    // R6: halt mid-period clears bit phase; restart counts 16 ticks afresh
    runCfg(3, 0, 10, "R3");
    @(negedge clk);
    divisor = '0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check("R6", int'(sampleTick), 0);
    end
    runCfg(2, 7, 17, "R4");

    // R9: largest divisor
    runCfg(8191, 0, 2, "R9");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule